// File: doc/BRIEF.md
# Symbol-Synchronous Spreading Code Modulator

This block turns a serial data stream into a direct-sequence spread-spectrum chip stream. A fixed 256-chip code store is read as a ring. Two host-written settings, a window start and a window length, pick the slice of that ring that forms the spreading code. Each data bit is XORed with exactly one pass over that slice. Bit boundaries therefore always fall on the first chip of the code. A receiver that has locked to the code also knows where each bit starts.

The chip rate comes from one of three single-cycle enable pulses chosen by a select input: the system tick, timer-0 or timer-1. Data bytes are written by the host into a one-byte hold register. From there they pass to a shift register, which sends them out MSB first, one bit per code window. When the hold register is empty at the moment a new byte is needed, zeros are sent and a sticky underrun flag is raised. Changing either window setting, or dropping the enable, restarts the sequence. The next chip then comes from the window start and begins a new bit of a new byte.

Top module: `pn_spreader`

## Requirements
- R1: Reset leaves `chip_valid`, `bit_start`, `chip_out` and `underrun` at 0 and `hold_empty` at 1. It sets the window start to 0 and the window length to 256.
- R2: A chip is produced in each cycle where all of the following hold: `enable` is 1, the pulse chosen by `ref_sel` is high, and no window write occurs. `ref_sel` maps 0 to `sys_tick`, 1 to `tmr0_tick` and 2 to `tmr1_tick`; 3 selects no pulse. `chip_valid` is high in the following cycle, and only then.
- R3: The k-th chip of a window reads code address (start + k) mod 256, so a window runs past address 255 and continues at 0. That code chip is XORed with the current data bit and appears on `chip_out`.
- R4: After the last chip of the window, reading resumes at the window start. A length value of 0 means 256 chips.
- R5: `bit_start` is high with the first chip of every window, and each data bit covers exactly one window of length L.
- R6: At the first chip of a byte, the shift register takes the byte from the hold register and `hold_empty` rises. Bits leave MSB first. A host data write fills the hold register and clears `hold_empty`.
- R7: If the hold register is empty when a byte is needed, zeros are sent and `underrun` is set. It stays set until the next host data write. When a fetch from an empty hold and a data write fall in the same cycle, setting wins.
- R8: The host write port uses `wr_sel` 0 for the data hold, 1 for the window start and 2 for the window length. Target 3 changes nothing. A write to the start or length, or `enable` low, restarts the sequence: the next chip reads the window start, raises `bit_start` and begins a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; low restarts the sequence |
| ref_sel | input | 2 | Chip-rate source select |
| sys_tick | input | 1 | System tick enable pulse |
| tmr0_tick | input | 1 | Timer-0 enable pulse |
| tmr1_tick | input | 1 | Timer-1 enable pulse |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Host write target |
| wr_data | input | 8 | Host write value |
| chip_out | output | 1 | Spread chip |
| chip_valid | output | 1 | Chip strobe, one cycle after the chip-rate pulse |
| bit_start | output | 1 | First chip of a code window and of a data bit |
| hold_empty | output | 1 | Hold register empty |
| underrun | output | 1 | Sticky underrun flag |

## Verification
A chip-rate pulse accepted in one cycle shows up as `chip_out`, `chip_valid` and `bit_start` in the next cycle. The effects of a fetch or data write on `hold_empty` and `underrun` are also visible one cycle later. A window write or an enable drop acts on the first pulse after it. The bench model updates its expected values on each rising edge from the inputs held since the last falling edge, and compares them with the outputs at the falling edge. Every result is therefore compared in exactly the cycle it is due. Directed checks then measure window spans, restart alignment and flag behaviour at those same falling edges.

// File: rtl/pn_pkg.sv
package pn_pkg;

    localparam int CODE_AW = 8;
    localparam int BYTE_W  = 8;

    typedef enum logic [1:0] {
        REF_SYS  = 2'd0,
        REF_TMR0 = 2'd1,
        REF_TMR1 = 2'd2,
        REF_NONE = 2'd3
    } ref_src_e;

    typedef enum logic [1:0] {
        TGT_DATA  = 2'd0,
        TGT_START = 2'd1,
        TGT_LEN   = 2'd2,
        TGT_NONE  = 2'd3
    } wr_tgt_e;

    typedef struct packed {
        logic first;
        logic last;
    } win_pos_t;

    typedef struct packed {
        logic chip;
        logic valid;
        logic first;
    } chip_out_t;

    // Maximal-length 8-bit LFSR (taps 8,6,5,4); the final chip is padded with 0.
    function automatic logic [(1 << CODE_AW) - 1:0] default_code();
        logic [(1 << CODE_AW) - 1:0] r;
        logic [7:0] s;
        r = '0;
        s = 8'h01;
        for (int i = 0; i < (1 << CODE_AW) - 1; i++) begin
            r[i] = s[0];
            s = {s[0] ^ s[2] ^ s[3] ^ s[4], s[7:1]};
        end
        return r;
    endfunction

    function automatic logic is_cfg_write(logic en, logic [1:0] sel);
        return en && (wr_tgt_e'(sel) == TGT_START || wr_tgt_e'(sel) == TGT_LEN);
    endfunction

endpackage

// File: rtl/pn_ref_select.sv
module pn_ref_select (
    input  logic [1:0] sel,
    input  logic       sys_tick,
    input  logic       tmr0_tick,
    input  logic       tmr1_tick,
    input  logic       run,
    output logic       tick
);
    import pn_pkg::*;

    logic pulse;

    always_comb begin
        unique case (ref_src_e'(sel))
            REF_SYS:  pulse = sys_tick;
            REF_TMR0: pulse = tmr0_tick;
            REF_TMR1: pulse = tmr1_tick;
            default:  pulse = 1'b0;
        endcase
    end

    assign tick = run && pulse;

endmodule

// File: rtl/pn_chip_seq.sv
module pn_chip_seq #(
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            restart,
    input  logic [AW-1:0]   start_addr,
    input  logic [AW-1:0]   code_len,
    output logic [AW-1:0]   rd_addr,
    output pn_pkg::win_pos_t pos
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] idx_q;
    logic [AW-1:0] last_idx;

    // Length 0 wraps to the all-ones index, i.e. a full-ring window.
    assign last_idx  = code_len - ONE;
    assign rd_addr   = start_addr + idx_q;
    assign pos.first = (idx_q == '0);
    assign pos.last  = (idx_q == last_idx);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            idx_q <= '0;
        end else if (tick) begin
            idx_q <= pos.last ? '0 : idx_q + ONE;
        end
    end

endmodule

// File: rtl/pn_data_path.sv
module pn_data_path #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          first_chip,
    input  logic          last_chip,
    input  logic          restart,
    input  logic          host_load,
    input  logic [DW-1:0] host_byte,
    output logic          cur_bit,
    output logic          hold_empty,
    output logic          underrun
);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

    logic [DW-1:0] hold_q;
    logic [DW-1:0] shreg_q;
    logic          full_q;
    logic          under_q;
    logic [BW-1:0] bitn_q;

    logic          fetch;
    logic [DW-1:0] fetched;
    logic [DW-1:0] src;

    assign fetch   = tick && first_chip && (bitn_q == '0);
    assign fetched = full_q ? hold_q : '0;
    assign src     = fetch ? fetched : shreg_q;
    assign cur_bit = src[DW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            bitn_q  <= '0;
        end else begin
            if (tick && last_chip) begin
                shreg_q <= src << 1;
                bitn_q  <= (bitn_q == LAST_BIT) ? '0 : bitn_q + BW'(1);
            end else if (fetch) begin
                shreg_q <= src;
            end
            if (restart) begin
                bitn_q <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            full_q  <= 1'b0;
            under_q <= 1'b0;
        end else begin
            if (host_load) begin
                hold_q <= host_byte;
            end
            full_q  <= host_load | (full_q & ~fetch);
            under_q <= (fetch & ~full_q) | (under_q & ~host_load);
        end
    end

    assign hold_empty = ~full_q;
    assign underrun   = under_q;

endmodule

// File: rtl/pn_spreader.sv
module pn_spreader #(
    parameter int ADDR_W = pn_pkg::CODE_AW,
    parameter int DATA_W = pn_pkg::BYTE_W,
    parameter logic [(1 << ADDR_W) - 1:0] CODE_ROM = pn_pkg::default_code()
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [1:0]        ref_sel,
    input  logic              sys_tick,
    input  logic              tmr0_tick,
    input  logic              tmr1_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              chip_out,
    output logic              chip_valid,
    output logic              bit_start,
    output logic              hold_empty,
    output logic              underrun
);
    import pn_pkg::*;

    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] len_q;
    logic              cfg_write;
    logic              data_load;
    logic              restart;
    logic              tick;
    logic [ADDR_W-1:0] rd_addr;
    win_pos_t          pos;
    logic              data_bit;
    chip_out_t         out_q;

    assign cfg_write = is_cfg_write(wr_en, wr_sel);
    assign data_load = wr_en && (wr_tgt_e'(wr_sel) == TGT_DATA);
    assign restart   = cfg_write || !enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            len_q   <= '0;
        end else if (wr_en) begin
            if (wr_tgt_e'(wr_sel) == TGT_START) start_q <= wr_data[ADDR_W-1:0];
            if (wr_tgt_e'(wr_sel) == TGT_LEN)   len_q   <= wr_data[ADDR_W-1:0];
        end
    end

    pn_ref_select u_ref (
        .sel       (ref_sel),
        .sys_tick  (sys_tick),
        .tmr0_tick (tmr0_tick),
        .tmr1_tick (tmr1_tick),
        .run       (enable && !cfg_write),
        .tick      (tick)
    );

    pn_chip_seq #(.AW(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .restart    (restart),
        .start_addr (start_q),
        .code_len   (len_q),
        .rd_addr    (rd_addr),
        .pos        (pos)
    );

    pn_data_path #(.DW(DATA_W)) u_data (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .first_chip (pos.first),
        .last_chip  (pos.last),
        .restart    (restart),
        .host_load  (data_load),
        .host_byte  (wr_data),
        .cur_bit    (data_bit),
        .hold_empty (hold_empty),
        .underrun   (underrun)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= tick;
            out_q.first <= tick && pos.first;
            if (tick) begin
                out_q.chip <= CODE_ROM[rd_addr] ^ data_bit;
            end
        end
    end

    assign chip_out   = out_q.chip;
    assign chip_valid = out_q.valid;
    assign bit_start  = out_q.first;

endmodule

// File: rtl/pn_spreader_chk.sv
module pn_spreader_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic [1:0]        ref_sel,
    input logic              sys_tick,
    input logic              tmr0_tick,
    input logic              tmr1_tick,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              chip_valid,
    input logic              bit_start,
    input logic              hold_empty,
    input logic              underrun
);
    localparam int CW = ADDR_W + 1;
    localparam logic [CW-1:0] FULL_LEN = CW'(1) << ADDR_W;

    logic          pulse;
    logic          cfg_w;
    logic          data_w;
    logic          tick;
    logic          fresh;
    logic [CW-1:0] cnt;
    logic [CW-1:0] len_m;

    always_comb begin
        case (ref_sel)
            2'd0:    pulse = sys_tick;
            2'd1:    pulse = tmr0_tick;
            2'd2:    pulse = tmr1_tick;
            default: pulse = 1'b0;
        endcase
    end

    assign cfg_w  = wr_en && (wr_sel == 2'd1 || wr_sel == 2'd2);
    assign data_w = wr_en && (wr_sel == 2'd0);
    assign tick   = enable && pulse && !cfg_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            fresh <= 1'b1;
            cnt   <= '0;
            len_m <= FULL_LEN;
        end else begin
            if (wr_en && wr_sel == 2'd2) begin
                len_m <= (wr_data[ADDR_W-1:0] == '0) ? FULL_LEN : {1'b0, wr_data[ADDR_W-1:0]};
            end
            fresh <= (cfg_w || !enable) ? 1'b1 : (chip_valid ? 1'b0 : fresh);
            if (chip_valid) cnt <= bit_start ? CW'(1) : cnt + CW'(1);
        end
    end

    p_tick_gives_chip_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> chip_valid);

    p_idle_no_chip_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !chip_valid);

    p_restart_aligns_r8: assert property (@(posedge clk) disable iff (rst)
        (chip_valid && fresh) |-> bit_start);

    p_bit_span_r5: assert property (@(posedge clk) disable iff (rst)
        (chip_valid && !fresh && !bit_start) |-> (cnt < len_m));

    p_window_wraps_r4: assert property (@(posedge clk) disable iff (rst)
        (chip_valid && !fresh && cnt == len_m) |-> bit_start);

    p_load_fills_r6: assert property (@(posedge clk) disable iff (rst)
        data_w |=> !hold_empty);

    p_under_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (underrun && !data_w) |=> underrun);

    p_under_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (data_w && !hold_empty) |=> !underrun);

endmodule

bind pn_spreader pn_spreader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .ref_sel    (ref_sel),
    .sys_tick   (sys_tick),
    .tmr0_tick  (tmr0_tick),
    .tmr1_tick  (tmr1_tick),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .chip_valid (chip_valid),
    .bit_start  (bit_start),
    .hold_empty (hold_empty),
    .underrun   (underrun)
);

// File: tb/sim_pn_spreader.sv
module sim_pn_spreader;

    localparam int CLK_PERIOD = 10;

    function automatic logic [255:0] mk_code();
        logic [255:0] r;
        for (int i = 0; i < 256; i++) begin
            int v;
            v = ((i * 73) ^ (i >> 1) ^ 91) & 255;
            r[i] = v[2] ^ v[5] ^ v[0];
        end
        return r;
    endfunction

    localparam logic [255:0] TB_CODE = mk_code();

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic [1:0] ref_sel = 2'd0;
    logic       sys_tick = 1'b0, tmr0_tick = 1'b0, tmr1_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       chip_out, chip_valid, bit_start, hold_empty, underrun;

    int checks = 0;
    int errors = 0;
    bit chk_on = 0;
    int tick_mode = 0;
    int cyc = 0;
    int unsigned lcg = 32'h1234_5678;
    logic [7:0] next_byte = 8'hA5;

    // reference model state
    int         m_start, m_len, m_k, m_bitn;
    logic [7:0] m_byte, m_hold;
    bit         m_full, m_under;
    bit         e_valid, e_bs, e_out, e_empty, e_under;

    pn_spreader #(.CODE_ROM(TB_CODE)) u0 (
        .clk(clk), .rst(rst), .enable(enable), .ref_sel(ref_sel),
        .sys_tick(sys_tick), .tmr0_tick(tmr0_tick), .tmr1_tick(tmr1_tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .chip_out(chip_out), .chip_valid(chip_valid), .bit_start(bit_start),
        .hold_empty(hold_empty), .underrun(underrun)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: evaluated on each rising edge from the held inputs.
    always @(posedge clk) begin
        bit cfgw, pl, tk, dataw, old_full, consumed, uset, bitv;
        logic [7:0] old_hold;
        cyc++;
        if (rst) begin
            m_start = 0; m_len = 256; m_k = 0; m_bitn = 0;
            m_byte = 0; m_hold = 0; m_full = 0; m_under = 0;
            e_valid = 0; e_bs = 0; e_out = 0;
        end else begin
            cfgw = wr_en && (wr_sel == 2'd1 || wr_sel == 2'd2);
            dataw = wr_en && (wr_sel == 2'd0);
            case (ref_sel)
                2'd0: pl = sys_tick;
                2'd1: pl = tmr0_tick;
                2'd2: pl = tmr1_tick;
                default: pl = 0;
            endcase
            tk = enable && pl && !cfgw;
            old_full = m_full; old_hold = m_hold; consumed = 0; uset = 0;
            e_valid = tk; e_bs = 0;
            if (tk) begin
                if (m_k == 0 && m_bitn == 0) begin
                    m_byte = old_full ? old_hold : 8'h00;
                    consumed = old_full;
                    uset = !old_full;
                end
                bitv = m_byte[7 - m_bitn];
                e_out = TB_CODE[(m_start + m_k) % 256] ^ bitv;
                e_bs = (m_k == 0);
                m_k++;
                if (m_k == m_len) begin
                    m_k = 0;
                    m_bitn = (m_bitn + 1) % 8;
                end
            end
            if (!enable || cfgw) begin
                m_k = 0; m_bitn = 0;
            end
            if (consumed) m_full = 0;
            if (dataw) begin m_hold = wr_data; m_full = 1; end
            m_under = uset ? 1 : (dataw ? 0 : m_under);
            if (wr_en && wr_sel == 2'd1) m_start = wr_data;
            if (wr_en && wr_sel == 2'd2) m_len = (wr_data == 0) ? 256 : wr_data;
        end
        e_empty = !m_full;
        e_under = m_under;
    end

    always @(negedge clk) begin
        if (chk_on) begin
            chk("R2 chip_valid", chip_valid, e_valid);
            chk("R5 bit_start", bit_start, e_bs);
            chk("R3 chip_out", chip_out, e_out);
            chk("R6 hold_empty", hold_empty, e_empty);
            chk("R7 underrun", underrun, e_under);
        end
    end

    // One stimulus cycle: drive pulses and optionally keep the hold fed.
    task automatic step(bit feed);
        bit pat;
        @(negedge clk);
        lcg = lcg * 32'd1103515245 + 32'd12345;
        case (tick_mode)
            0: pat = 1'b1;
            1: pat = (cyc % 3 == 0);
            default: pat = lcg[20];
        endcase
        sys_tick  = (ref_sel == 2'd0) ? pat : lcg[17];
        tmr0_tick = (ref_sel == 2'd1) ? pat : lcg[23];
        tmr1_tick = (ref_sel == 2'd2) ? pat : lcg[27];
        wr_en = 0;
        if (feed && hold_empty) begin
            wr_en = 1; wr_sel = 2'd0; wr_data = next_byte;
            next_byte = {next_byte[6:0], next_byte[7] ^ next_byte[5]} + 8'd29;
        end
    endtask

    task automatic write(logic [1:0] sel, logic [7:0] val);
        @(negedge clk);
        lcg = lcg * 32'd1103515245 + 32'd12345;
        sys_tick = lcg[9]; tmr0_tick = lcg[13]; tmr1_tick = lcg[19];
        wr_en = 1; wr_sel = sel; wr_data = val;
    endtask

    task automatic run(int n, bit feed);
        for (int i = 0; i < n; i++) step(feed);
    endtask

    // Counts chips from one bit_start up to the next.
    task automatic span(int exp, string req);
        int n = 0;
        int guard = 0;
        while (!(chip_valid && bit_start) && guard < 5000) begin step(1); guard++; end
        n = 1;
        step(1);
        while (!(chip_valid && bit_start) && guard < 5000) begin
            if (chip_valid) n++;
            step(1);
            guard++;
        end
        chk(req, n, exp);
    endtask

    task automatic first_after_restart(string req);
        int guard = 0;
        step(1);
        while (!chip_valid && guard < 2000) begin step(1); guard++; end
        chk(req, bit_start, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 chip_valid", chip_valid, 0);
        chk("R1 bit_start", bit_start, 0);
        chk("R1 chip_out", chip_out, 0);
        chk("R1 underrun", underrun, 0);
        chk("R1 hold_empty", hold_empty, 1);
        rst = 0;
        chk_on = 1;

        // default window (256), then a short one
        write(2'd0, 8'hC3);
        write(2'd1, 8'd10);
        write(2'd2, 8'd5);
        enable = 1; tick_mode = 0; ref_sel = 2'd0;
        run(200, 1);
        span(5, "R5 bit span len5");

        // wrapping window, timer-0 pace; R8 restart on start write
        write(2'd2, 8'd12);
        write(2'd1, 8'd250);
        tick_mode = 1; ref_sel = 2'd1;
        first_after_restart("R8 start write aligns");
        run(400, 1);
        span(12, "R3 wrap window span");
        write(2'd3, 8'h77); // ignored target
        run(100, 1);

        // full ring via length 0, timer-1 random pace
        write(2'd2, 8'd0);
        tick_mode = 2; ref_sel = 2'd2;
        first_after_restart("R8 length write aligns");
        span(256, "R4 length 0 is 256");

        // one-chip window, every cycle
        write(2'd2, 8'd1);
        write(2'd1, 8'd255);
        tick_mode = 0; ref_sel = 2'd0;
        run(120, 1);

        // starve the hold register
        run(60, 0);
        chk("R7 underrun raised", underrun, 1);
        chk("R6 hold empty when starved", hold_empty, 1);
        enable = 0;
        step(0);
        step(1);
        step(0);
        chk("R7 write clears underrun", underrun, 0);
        chk("R6 write fills hold", hold_empty, 0);

        // re-enable after a stop
        enable = 1;
        write(2'd2, 8'd3);
        run(30, 1);
        enable = 0;
        run(4, 1);
        enable = 1;
        first_after_restart("R8 enable restart aligns");
        run(50, 1);

        // no source selected
        ref_sel = 2'd3;
        begin
            int seen = 0;
            step(1);
            for (int i = 0; i < 50; i++) begin
                step(1);
                if (chip_valid) seen++;
            end
            chk("R2 select 3 gives no chips", seen, 0);
        end

        step(0);
        chk_on = 0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule